// File: doc/BRIEF.md
# Machine-Cycle Refresh, Reset and Bus-Grant Controller

This block sits between the instruction sequencer of an 8-bit processor and its external pins. Each clock the sequencer reports the state of the current machine cycle: whether it is an opcode fetch, a prefix fetch or a refresh slot, which strobes it wants and whether the cycle ends. The block decides what actually reaches the pins. It stalls the cycle on an external wait. It hands the bus to an external master at the end of a machine cycle. It blanks everything during reset.

The block also holds the processor state that these jobs need. That state is a refresh counter that advances on fetches, a vector page register, the interrupt mode and the interrupt-enable flip-flop. In the vectored interrupt mode it builds the 16-bit table address at the end of an acknowledge cycle. The external reset pin is filtered, so that only a pulse of at least three clocks restarts the processor. A separate asynchronous power-on reset clears all flops, and its release is synchronised.

Top module: `mcyc_ctl`

## Requirements
- R1: The `core_rst` output rises after the third consecutive rising edge at which `cpu_rst_n` is low, and falls after the first edge at which `cpu_rst_n` is high. A pulse that spans only one or two edges leaves every register unchanged.
- R2: The clock edge after `core_rst` is high clears `rfsh_q`, `page_q`, `ie_q`, `vec_addr` and `vec_vld`. It sets `im_q` to 0 and drops any bus grant or pending NMI. The power-on reset `rst_n` leaves the same state.
- R3: While `core_rst` is high, `addr_oe` and `dout_oe` are 0 and `addr` is 0. `strb_oe` is 1, and `mreq_n`, `iorq_n`, `rd_n`, `wr_n`, `m1_n`, `rfsh_n` and `busack_n` are all 1.
- R4: A machine cycle ends effectively at a rising edge where `seq_end`=1 and `wait_n`=1, with no reset and no bus grant. At such an end, if `st_opf` or `st_pfx` is 1, bits 6:0 of `rfsh_q` increment by one, wrapping 127 to 0. Bit 7 never changes except by a write or a reset.
- R5: With `wait_n`=0, `core_hold` is 1 and a `seq_end` has no effect: no refresh count, no bus grant, no NMI take and no vector capture.
- R6: When `seq_rfsh`=1 and the bus is driven, `addr` = {`page_q`, `rfsh_q`}. Otherwise it equals `seq_addr`.
- R7: `reg_we_rfsh` and `reg_we_page` load `reg_wdata` at the next edge, and a refresh write wins over a same-cycle increment. `im_we` loads `im_val`. `ie_clr` clears `ie_q` and wins over `ie_set`.
- R8: At an effective end with `seq_m1`=`seq_iorq`=1 and `im_q`=2, `vec_addr` becomes {`page_q`, `din`} and `vec_vld` is 1 for one cycle. In modes 0, 1 and 3 nothing is captured.
- R9: `intack` is 1 exactly when `seq_m1` and `seq_iorq` are both 1 while the bus is driven.
- R10: `busrq_n` is sampled only at an effective end. If it is low there, `busack_n` goes low from the next cycle. While granted, `addr_oe`, `dout_oe` and `strb_oe` are 0 and `core_hold` is 1. The grant ends the cycle after `busrq_n` is seen high.
- R11: A falling edge on `nmi_n` is latched. At the next effective end with `busrq_n` high, `nmi_take` pulses for one cycle. If `busrq_n` is low at that end, the bus grant wins and the NMI stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| cpu_rst_n | input | 1 | External processor reset pin, active low, filtered |
| wait_n | input | 1 | Wait request, active low |
| busrq_n | input | 1 | External bus request, active low |
| nmi_n | input | 1 | Non-maskable interrupt, falling-edge sensitive |
| st_opf | input | 1 | Current machine cycle is an opcode fetch |
| st_pfx | input | 1 | Current machine cycle is a prefix fetch |
| seq_end | input | 1 | Sequencer says this clock ends the machine cycle |
| seq_m1 | input | 1 | Sequencer first-cycle marker |
| seq_mreq | input | 1 | Sequencer memory request |
| seq_iorq | input | 1 | Sequencer I/O request |
| seq_rd | input | 1 | Sequencer read strobe |
| seq_wr | input | 1 | Sequencer write strobe |
| seq_rfsh | input | 1 | Sequencer refresh slot |
| seq_doe | input | 1 | Sequencer wants to drive the data bus |
| seq_addr | input | 16 | Sequencer address |
| din | input | 8 | Data bus input (device vector byte) |
| reg_we_rfsh | input | 1 | Write refresh counter |
| reg_we_page | input | 1 | Write vector page register |
| reg_wdata | input | 8 | Write data |
| im_we | input | 1 | Write interrupt mode |
| im_val | input | 2 | Interrupt mode value |
| ie_set | input | 1 | Set interrupt enable |
| ie_clr | input | 1 | Clear interrupt enable |
| addr | output | 16 | Address pins value |
| addr_oe | output | 1 | Address bus enable |
| dout_oe | output | 1 | Data bus drive enable |
| strb_oe | output | 1 | Enable for mreq_n, iorq_n, rd_n, wr_n |
| mreq_n | output | 1 | Memory request pin |
| iorq_n | output | 1 | I/O request pin |
| rd_n | output | 1 | Read pin |
| wr_n | output | 1 | Write pin |
| m1_n | output | 1 | First-cycle pin |
| rfsh_n | output | 1 | Refresh pin |
| busack_n | output | 1 | Bus acknowledge pin |
| intack | output | 1 | Interrupt acknowledge cycle in progress |
| core_hold | output | 1 | Sequencer must hold its state |
| core_rst | output | 1 | Processor reset to sequencer (clears program counter) |
| nmi_take | output | 1 | One-cycle pulse: start NMI service |
| rfsh_q | output | 8 | Refresh counter |
| page_q | output | 8 | Vector page register |
| im_q | output | 2 | Interrupt mode |
| ie_q | output | 1 | Interrupt enable flip-flop |
| vec_addr | output | 16 | Captured vector table address |
| vec_vld | output | 1 | vec_addr updated this cycle |

## Verification
The bench drives the reset pin low for two edges and then for three. A filter with an off-by-one error would either clear the vector page after the short pulse or keep it after the long one. It steps the refresh counter across 127 with bit 7 set, which catches a design that counts all eight bits or loses the top bit. Stalls land on cycle ends, and bus requests arrive mid-cycle and together with a pending NMI. A design that sampled the request early, granted during a wait, or let the NMI win would mismatch the cycle-accurate model. Acknowledge cycles run in every interrupt mode to expose captures outside the vectored mode.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  // interrupt mode that uses the page register and device byte
  localparam logic [1:0] IM_VECTORED = 2'd2;
  // strobe lanes gated by the controller
  localparam int NUM_STB = 4;
  typedef enum int {STB_WR = 0, STB_RD = 1, STB_IORQ = 2, STB_MREQ = 3} stb_lane_e;
endpackage

// File: rtl/mcc_rst_filt.sv
module mcc_rst_filt #(
  parameter int MIN_CYC = 3
) (
  input  logic clk,
  input  logic arst_n,
  input  logic pin_n,
  output logic rst_q
);
  localparam int CW = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(MIN_CYC);
  localparam logic [CW-1:0] CNT_ARM = CW'(MIN_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          rst_d;

  always_comb begin
    if (pin_n) begin
      cnt_d = '0;
      rst_d = 1'b0;
    end else begin
      cnt_d = (cnt_q == CNT_TOP) ? cnt_q : cnt_q + 1'b1;
      rst_d = (cnt_q >= CNT_ARM);
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q <= '0;
      rst_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rst_q <= rst_d;
    end
  end

  // R1: the filtered reset can only be high if the pin was low at the last edge
  assert_rst_needs_pin_R1: assert property (@(posedge clk) disable iff (!arst_n)
    rst_q |-> !$past(pin_n));
  // R1: the filtered reset rises only once the run length is complete
  assert_rst_rise_len_R1: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(rst_q) |-> (cnt_q == CNT_TOP));
endmodule

// File: rtl/mcc_rfsh.sv
module mcc_rfsh #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          clr,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  input  logic          inc,
  output logic [DW-1:0] q
);
  localparam int CB = DW - 1;

  logic [DW-1:0] q_d;

  always_comb begin
    q_d = q;
    if (clr)       q_d = '0;
    else if (we)   q_d = wdata;
    else if (inc)  q_d = {q[DW-1], q[CB-1:0] + 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) q <= '0;
    else         q <= q_d;
  end

  // R4: top bit is untouched by counting
  assert_top_bit_kept_R4: assert property (@(posedge clk) disable iff (!arst_n)
    (!we && !clr) |=> (q[DW-1] == $past(q[DW-1])));
  // R4: low field moves by at most one step per clock
  assert_single_step_R4: assert property (@(posedge clk) disable iff (!arst_n)
    (!we && !clr) |=> ((q[CB-1:0] == $past(q[CB-1:0])) ||
                       (q[CB-1:0] == $past(q[CB-1:0]) + 1'b1)));
endmodule

// File: rtl/mcc_arb.sv
module mcc_arb (
  input  logic clk,
  input  logic arst_n,
  input  logic clr,
  input  logic seq_end,
  input  logic wait_n,
  input  logic busrq_n,
  input  logic nmi_n,
  output logic granted,
  output logic eff_end,
  output logic nmi_take
);
  logic gr_d, nprev_q, pend_q, pend_d, take_d;
  logic nmi_fall, take_now;

  assign eff_end  = seq_end & wait_n & ~clr & ~granted;
  assign nmi_fall = nprev_q & ~nmi_n;
  assign take_now = eff_end & busrq_n & pend_q;

  always_comb begin
    if (clr) begin
      gr_d   = 1'b0;
      pend_d = 1'b0;
      take_d = 1'b0;
    end else begin
      gr_d   = granted ? ~busrq_n : (eff_end & ~busrq_n);
      pend_d = (pend_q | nmi_fall) & ~take_now;
      take_d = take_now;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      granted  <= 1'b0;
      nprev_q  <= 1'b1;
      pend_q   <= 1'b0;
      nmi_take <= 1'b0;
    end else begin
      granted  <= gr_d;
      nprev_q  <= nmi_n;
      pend_q   <= pend_d;
      nmi_take <= take_d;
    end
  end

  // R10: a grant starts only from a sampled request at an unstalled cycle end
  assert_grant_at_end_R10: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(granted) |-> $past(seq_end && wait_n && !busrq_n));
  // R11: the bus request outranks the non-maskable interrupt
  assert_nmi_loses_to_bus_R11: assert property (@(posedge clk) disable iff (!arst_n)
    nmi_take |-> ($past(busrq_n) && !granted));
  // R5: nothing is taken at a stalled end
  assert_wait_blocks_R5: assert property (@(posedge clk) disable iff (!arst_n)
    !wait_n |=> !nmi_take);
endmodule

// File: rtl/mcc_vec.sv
module mcc_vec import mcc_pkg::*; #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          clr,
  input  logic          page_we,
  input  logic          im_we,
  input  logic [1:0]    im_val,
  input  logic          ie_set,
  input  logic          ie_clr,
  input  logic [DW-1:0] wdata,
  input  logic          ack_end,
  input  logic [DW-1:0] din,
  output logic [AW-DW-1:0] page_q,
  output logic [1:0]    im_q,
  output logic          ie_q,
  output logic [AW-1:0] vec_addr,
  output logic          vec_vld
);
  localparam int PW = AW - DW;

  logic [PW-1:0] page_d;
  logic [1:0]    im_d;
  logic          ie_d, vld_d, cap;
  logic [AW-1:0] va_d;

  assign cap = ack_end & (im_q == IM_VECTORED);

  always_comb begin
    page_d = page_q;
    im_d   = im_q;
    ie_d   = ie_q;
    va_d   = vec_addr;
    vld_d  = 1'b0;
    if (clr) begin
      page_d = '0;
      im_d   = '0;
      ie_d   = 1'b0;
      va_d   = '0;
    end else begin
      if (page_we) page_d = wdata[PW-1:0];
      if (im_we)   im_d   = im_val;
      if (ie_clr)      ie_d = 1'b0;
      else if (ie_set) ie_d = 1'b1;
      if (cap) begin
        va_d  = {page_q, din};
        vld_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      page_q   <= '0;
      im_q     <= '0;
      ie_q     <= 1'b0;
      vec_addr <= '0;
      vec_vld  <= 1'b0;
    end else begin
      page_q   <= page_d;
      im_q     <= im_d;
      ie_q     <= ie_d;
      vec_addr <= va_d;
      vec_vld  <= vld_d;
    end
  end

  // R8: the upper half of a captured vector is the page seen at capture
  assert_vec_page_R8: assert property (@(posedge clk) disable iff (!arst_n)
    vec_vld |-> (vec_addr[AW-1:DW] == $past(page_q)));
  // R8: capture only in the vectored mode
  assert_vec_mode_R8: assert property (@(posedge clk) disable iff (!arst_n)
    vec_vld |-> ($past(im_q) == IM_VECTORED));
endmodule

// File: rtl/mcyc_ctl.sv
module mcyc_ctl import mcc_pkg::*; #(
  parameter int AW       = 16,
  parameter int DW       = 8,
  parameter int RST_MIN  = 3,
  parameter int SYNC_STG = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_rst_n,
  input  logic          wait_n,
  input  logic          busrq_n,
  input  logic          nmi_n,
  input  logic          st_opf,
  input  logic          st_pfx,
  input  logic          seq_end,
  input  logic          seq_m1,
  input  logic          seq_mreq,
  input  logic          seq_iorq,
  input  logic          seq_rd,
  input  logic          seq_wr,
  input  logic          seq_rfsh,
  input  logic          seq_doe,
  input  logic [AW-1:0] seq_addr,
  input  logic [DW-1:0] din,
  input  logic          reg_we_rfsh,
  input  logic          reg_we_page,
  input  logic [DW-1:0] reg_wdata,
  input  logic          im_we,
  input  logic [1:0]    im_val,
  input  logic          ie_set,
  input  logic          ie_clr,
  output logic [AW-1:0] addr,
  output logic          addr_oe,
  output logic          dout_oe,
  output logic          strb_oe,
  output logic          mreq_n,
  output logic          iorq_n,
  output logic          rd_n,
  output logic          wr_n,
  output logic          m1_n,
  output logic          rfsh_n,
  output logic          busack_n,
  output logic          intack,
  output logic          core_hold,
  output logic          core_rst,
  output logic          nmi_take,
  output logic [DW-1:0] rfsh_q,
  output logic [AW-DW-1:0] page_q,
  output logic [1:0]    im_q,
  output logic          ie_q,
  output logic [AW-1:0] vec_addr,
  output logic          vec_vld
);
  // power-on reset: asserted asynchronously, released through a flop chain
  logic [SYNC_STG-1:0] sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STG-2:0], 1'b1};
  end

  logic rst_sync_n, rst_q, quiet, granted, eff_end, block, bus_en;
  assign rst_sync_n = sync_q[SYNC_STG-1];
  assign quiet      = rst_q | ~rst_sync_n;
  assign block      = quiet | granted;
  assign bus_en     = ~block;

  mcc_rst_filt #(.MIN_CYC(RST_MIN)) u_filt (
    .clk    (clk),
    .arst_n (rst_sync_n),
    .pin_n  (cpu_rst_n),
    .rst_q  (rst_q)
  );

  mcc_arb u_arb (
    .clk      (clk),
    .arst_n   (rst_sync_n),
    .clr      (quiet),
    .seq_end  (seq_end),
    .wait_n   (wait_n),
    .busrq_n  (busrq_n),
    .nmi_n    (nmi_n),
    .granted  (granted),
    .eff_end  (eff_end),
    .nmi_take (nmi_take)
  );

  mcc_rfsh #(.DW(DW)) u_rfsh (
    .clk    (clk),
    .arst_n (rst_sync_n),
    .clr    (quiet),
    .we     (reg_we_rfsh),
    .wdata  (reg_wdata),
    .inc    (eff_end & (st_opf | st_pfx)),
    .q      (rfsh_q)
  );

  mcc_vec #(.AW(AW), .DW(DW)) u_vec (
    .clk      (clk),
    .arst_n   (rst_sync_n),
    .clr      (quiet),
    .page_we  (reg_we_page),
    .im_we    (im_we),
    .im_val   (im_val),
    .ie_set   (ie_set),
    .ie_clr   (ie_clr),
    .wdata    (reg_wdata),
    .ack_end  (eff_end & seq_m1 & seq_iorq),
    .din      (din),
    .page_q   (page_q),
    .im_q     (im_q),
    .ie_q     (ie_q),
    .vec_addr (vec_addr),
    .vec_vld  (vec_vld)
  );

  // pin strobes: one lane per request, blanked to inactive when blocked
  logic [NUM_STB-1:0] stb_req, stb_pin_n;
  assign stb_req[STB_MREQ] = seq_mreq;
  assign stb_req[STB_IORQ] = seq_iorq;
  assign stb_req[STB_RD]   = seq_rd;
  assign stb_req[STB_WR]   = seq_wr;

  for (genvar g = 0; g < NUM_STB; g++) begin : g_stb
    assign stb_pin_n[g] = block | ~stb_req[g];
  end

  assign mreq_n = stb_pin_n[STB_MREQ];
  assign iorq_n = stb_pin_n[STB_IORQ];
  assign rd_n   = stb_pin_n[STB_RD];
  assign wr_n   = stb_pin_n[STB_WR];
  assign m1_n   = block | ~seq_m1;
  assign rfsh_n = block | ~seq_rfsh;

  assign addr_oe   = bus_en;
  assign dout_oe   = bus_en & seq_doe;
  assign strb_oe   = quiet | ~granted;
  assign addr      = bus_en ? (seq_rfsh ? {page_q, rfsh_q} : seq_addr) : '0;
  assign busack_n  = ~(granted & ~quiet);
  assign intack    = bus_en & seq_m1 & seq_iorq;
  assign core_hold = ~wait_n | block;
  assign core_rst  = quiet;

  // R10: acknowledge appears only one cycle after an unstalled end with a request
  assert_ack_follows_end_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(busack_n) |-> ($past(eff_end) && !$past(busrq_n)));
  // R3: reset keeps the bus undriven regardless of grant state
  assert_reset_quiet_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rst_q |-> (busack_n && !addr_oe && strb_oe));
endmodule

// File: tb/sim_mcyc_ctl.sv
module sim_mcyc_ctl;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, cpu_rst_n, wait_n, busrq_n, nmi_n, st_opf, st_pfx, seq_end;
  logic seq_m1, seq_mreq, seq_iorq, seq_rd, seq_wr, seq_rfsh, seq_doe;
  logic [15:0] seq_addr;
  logic [7:0]  din, reg_wdata;
  logic reg_we_rfsh, reg_we_page, im_we, ie_set, ie_clr;
  logic [1:0] im_val;
  logic [15:0] addr, vec_addr;
  logic addr_oe, dout_oe, strb_oe, mreq_n, iorq_n, rd_n, wr_n, m1_n, rfsh_n;
  logic busack_n, intack, core_hold, core_rst, nmi_take, ie_q, vec_vld;
  logic [7:0] rfsh_q, page_q;
  logic [1:0] im_q;

  mcyc_ctl u0 (.*);

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_sync, m_cnt;
  bit m_rst, m_ie, m_gr, m_np, m_pend, m_take, m_vv;
  logic [7:0] m_rf, m_pg;
  logic [1:0] m_im;
  logic [15:0] m_va;

  task automatic m_clear();
    m_cnt = 0; m_rst = 0; m_rf = 0; m_pg = 0; m_im = 0; m_ie = 0;
    m_gr = 0; m_pend = 0; m_take = 0; m_va = 0; m_vv = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sync = 0; m_clear(); m_np = 1;
    end else if (m_sync < 2) begin
      m_sync++; m_clear(); m_np = 1;
    end else begin
      bit q, eend, fall, tk, n_rst;
      int n_cnt;
      q    = m_rst;
      eend = seq_end && wait_n && !q && !m_gr;
      fall = m_np && !nmi_n;
      tk   = eend && busrq_n && m_pend;
      n_cnt = cpu_rst_n ? 0 : ((m_cnt >= 3) ? 3 : m_cnt + 1);
      n_rst = !cpu_rst_n && (m_cnt >= 2);
      if (q) begin
        m_rf = 0; m_pg = 0; m_im = 0; m_ie = 0; m_gr = 0;
        m_pend = 0; m_take = 0; m_va = 0; m_vv = 0;
      end else begin
        if (reg_we_rfsh) m_rf = reg_wdata;
        else if (eend && (st_opf || st_pfx)) m_rf = (m_rf & 8'h80) | ((m_rf + 8'd1) & 8'h7f);
        m_vv = 0;
        if (eend && seq_m1 && seq_iorq && m_im == 2'd2) begin
          m_va = {m_pg, din}; m_vv = 1;
        end
        if (reg_we_page) m_pg = reg_wdata;
        if (im_we) m_im = im_val;
        if (ie_clr) m_ie = 0; else if (ie_set) m_ie = 1;
        m_gr   = m_gr ? !busrq_n : (eend && !busrq_n);
        m_pend = (m_pend || fall) && !tk;
        m_take = tk;
      end
      m_np = nmi_n;
      m_cnt = n_cnt; m_rst = n_rst;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit q, blk, en;
      logic [15:0] ea;
      q   = m_rst || (m_sync < 2);
      blk = q || m_gr;
      en  = !blk;
      ea  = en ? (seq_rfsh ? {m_pg, m_rf} : seq_addr) : 16'h0;
      chk(core_rst == q, "R1 core_rst", core_rst, q);
      chk({addr_oe, strb_oe} == {en, (q || !m_gr)}, "R3 R10 oe", {addr_oe, strb_oe}, {en, (q || !m_gr)});
      chk(dout_oe == (en && seq_doe), "R10 dout_oe", dout_oe, en && seq_doe);
      chk({mreq_n, iorq_n, rd_n, wr_n, m1_n, rfsh_n} ==
          {blk || !seq_mreq, blk || !seq_iorq, blk || !seq_rd, blk || !seq_wr, blk || !seq_m1, blk || !seq_rfsh},
          "R3 strobes", {mreq_n, iorq_n, rd_n, wr_n, m1_n, rfsh_n}, 0);
      chk(addr == ea, "R6 addr", addr, ea);
      chk(busack_n == !(m_gr && !q), "R10 busack_n", busack_n, !(m_gr && !q));
      chk(intack == (en && seq_m1 && seq_iorq), "R9 intack", intack, en && seq_m1 && seq_iorq);
      chk(core_hold == (!wait_n || blk), "R5 core_hold", core_hold, !wait_n || blk);
      chk(nmi_take == m_take, "R11 nmi_take", nmi_take, m_take);
      chk(rfsh_q == m_rf, "R4 R7 rfsh_q", rfsh_q, m_rf);
      chk(page_q == m_pg, "R7 page_q", page_q, m_pg);
      chk({im_q, ie_q} == {m_im, m_ie}, "R2 im/ie", {im_q, ie_q}, {m_im, m_ie});
      chk({vec_vld, vec_addr} == {m_vv, m_va}, "R8 vector", {vec_vld, vec_addr}, {m_vv, m_va});
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(input int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic idle();
    {st_opf, st_pfx, seq_end, seq_m1, seq_mreq, seq_iorq, seq_rd, seq_wr, seq_rfsh, seq_doe} = '0;
    {reg_we_rfsh, reg_we_page, im_we, ie_set, ie_clr} = '0;
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk); wd++;
      if (wd > 100000 && !done) begin
        done = 1; bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 0; cpu_rst_n = 1; wait_n = 1; busrq_n = 1; nmi_n = 1;
    seq_addr = 16'h1234; din = 0; reg_wdata = 0; im_val = 0;
    idle();
    tick(3); rst_n = 1; tick(4);
    chk(rfsh_q == 8'h00 && page_q == 8'h00 && im_q == 2'd0, "R2 power-on state", {rfsh_q, page_q}, 0);

    // R7 writes
    reg_we_rfsh = 1; reg_we_page = 1; reg_wdata = 8'hfd; tick(); idle();
    reg_we_page = 1; reg_wdata = 8'h12; im_we = 1; im_val = 2'd2; ie_set = 1; tick(); idle();
    // R4 wrap with bit 7 set
    st_opf = 1; seq_end = 1; tick(5); idle();
    chk(rfsh_q == 8'h82, "R4 wrap keeps bit7", rfsh_q, 8'h82);
    // R5 stalled end
    st_pfx = 1; seq_end = 1; wait_n = 0; tick(3); wait_n = 1; tick(); idle();
    chk(rfsh_q == 8'h83, "R5 stall no count", rfsh_q, 8'h83);
    // R7 write beats increment
    st_opf = 1; seq_end = 1; reg_we_rfsh = 1; reg_wdata = 8'h40; tick(); idle();
    chk(rfsh_q == 8'h40, "R7 write wins", rfsh_q, 8'h40);
    // R6 refresh slot
    seq_rfsh = 1; seq_mreq = 1; #1;
    chk(addr == 16'h1240, "R6 refresh addr", addr, 16'h1240);
    tick(); idle();
    // R8 acknowledge in vectored mode then in mode 1
    seq_m1 = 1; seq_iorq = 1; din = 8'h6e; seq_end = 1; tick(); idle(); #1;
    chk(vec_vld && vec_addr == 16'h126e, "R8 vector capture", vec_addr, 16'h126e);
    im_we = 1; im_val = 2'd1; tick(); idle();
    seq_m1 = 1; seq_iorq = 1; din = 8'h22; seq_end = 1; tick(); idle(); #1;
    chk(!vec_vld && vec_addr == 16'h126e, "R8 no capture mode1", vec_addr, 16'h126e);
    // R1 short pulse ignored
    cpu_rst_n = 0; tick(2); cpu_rst_n = 1; tick(2);
    chk(page_q == 8'h12 && ie_q == 1'b1, "R1 two-cycle pulse ignored", page_q, 8'h12);
    // R1 / R2 three-cycle pulse
    cpu_rst_n = 0; tick(3); cpu_rst_n = 1; tick(2);
    chk(page_q == 8'h00 && ie_q == 1'b0 && rfsh_q == 8'h00, "R2 three-cycle pulse clears", page_q, 0);
    // R10 request only sampled at end
    busrq_n = 0; tick(3);
    chk(busack_n == 1'b1, "R10 no grant mid-cycle", busack_n, 1);
    seq_end = 1; tick(); idle(); tick(2);
    chk(busack_n == 1'b0 && addr_oe == 1'b0, "R10 granted", busack_n, 0);
    // R11 NMI arrives during grant, then release
    nmi_n = 0; tick(2); busrq_n = 1; tick(2);
    seq_end = 1; tick(); idle(); nmi_n = 1; tick(2);
    // R11 NMI and request at the same end
    nmi_n = 0; tick(); busrq_n = 0; seq_end = 1; tick(); idle(); nmi_n = 1; tick(3);
    busrq_n = 1; tick(2); seq_end = 1; tick(); idle(); tick(3);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int rl;
      seq_end  = ($urandom % 2) == 0;
      st_opf   = ($urandom % 10) < 3;
      st_pfx   = ($urandom % 10) == 0;
      seq_m1   = ($urandom % 4) == 0;
      seq_iorq = ($urandom % 4) == 0;
      seq_mreq = $urandom % 2; seq_rd = $urandom % 2; seq_wr = $urandom % 2;
      seq_rfsh = ($urandom % 5) == 0; seq_doe = $urandom % 2;
      seq_addr = 16'($urandom); din = 8'($urandom);
      wait_n   = ($urandom % 5) != 0;
      if (($urandom % 20) == 0) busrq_n = ~busrq_n;
      if (($urandom % 20) == 0) nmi_n = ~nmi_n;
      reg_we_rfsh = ($urandom % 20) == 0; reg_we_page = ($urandom % 20) == 0;
      reg_wdata = 8'($urandom);
      im_we = ($urandom % 10) == 0; im_val = 2'($urandom);
      ie_set = ($urandom % 8) == 0; ie_clr = ($urandom % 8) == 0;
      if (($urandom % 150) == 0) begin
        rl = 1 + ($urandom % 5);
        cpu_rst_n = 0; tick(rl); cpu_rst_n = 1;
      end else tick();
    end
    idle(); busrq_n = 1; nmi_n = 1; wait_n = 1; tick(3);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule